// File: doc/BRIEF.md
# GPIO Bank Register File with Masked Writes

This block holds the control state for one bank of 32 general-purpose pins, grouped as four ports of eight pins. Each port has a configure register, an output-enable register, an output-value register, an interrupt enable register and an interrupt type register. It also has a read-only input register that returns the synchronised pad levels. Software reaches the registers over a simple single-cycle 32-bit register bus with an address, write data, a write strobe and combinational read data.

Every writable register also appears a second time, at a fixed offset set by a parameter. A write to this masked alias changes only selected pins. Bits 15:8 of the write data choose which pins change, and bits 7:0 give their new values. A driver can therefore set or clear one pin in a single bus cycle, with no read-modify-write race against other pins. A pin drives its pad only when both its configure bit and its output-enable bit are set.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads zero and no pad is driven (`pad_oe_o` is all zero).
- R2: A plain write to the configure (0x00), output-enable (0x10) or output (0x20) register of port p, at function base + 4*p, replaces all eight bits of that port with write data 7:0. Reads of these registers and of the input register return zero in bits 31:8.
- R3: A write to the masked alias (plain address + UPPER_OFS, default 0x800) changes pin n of the port only when write data bit 8+n is 1. That pin then takes write data bit n, and every other bit keeps its value.
- R4: `pad_o` carries the output register bits. `pad_oe_o` bit k is 1 only when configure bit k and output-enable bit k are both 1. Bit k of each pad vector is pin k%8 of port k/8.
- R5: The input register of port p (0x30 + 4*p) returns `pad_i` bits 8p+7:8p after two clock edges of synchronisation. It still shows the old level after one edge.
- R6: Writes to the input register, to its alias, to interrupt status (0x40) and to interrupt clear (0x70) change no register and no pad output. Interrupt status reads zero.
- R7: The interrupt enable register (0x50 + 4*p) holds 8 bits. The interrupt type register (0x60 + 4*p) holds 24 bits, replaced by data 23:0 on a plain write. A masked write to the type register alters bits 7:0 only, under the same rule as R3.
- R8: Unaligned addresses, addresses with any bit set outside the function, port and alias fields, and reads of alias addresses return zero. Writes to such addresses have no effect.
- R9: A write to one port leaves the registers and pad outputs of every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address within the bank |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| pad_i | input | PORTS*PINS | Pad input levels (asynchronous) |
| pad_o | output | PORTS*PINS | Pad output values |
| pad_oe_o | output | PORTS*PINS | Pad drive enables |

## Verification
The bench targets the masked-write merge. It uses masks that select some pins, all pins or none. A design that swapped the mask and value bytes, or ignored the mask, would overwrite neighbouring pins, and the readback would show it. It checks the input path in the cycle between the first and second synchroniser stages, to catch a path that is one flop short. It also checks the edges of the address decode: unaligned offsets, stray upper address bits, reads of alias addresses, and writes to the read-only input and status registers. A decoder that dropped any of these would corrupt a live port register or return nonzero data. The type register's masked alias is checked to leave bits 23:8 intact, which catches a merge applied over the full width.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    FN_CNF = 3'd0,
    FN_OE  = 3'd1,
    FN_OUT = 3'd2,
    FN_IN  = 3'd3,
    FN_STA = 3'd4,
    FN_ENB = 3'd5,
    FN_LVL = 3'd6,
    FN_CLR = 3'd7
  } gpio_fn_e;
endpackage

// File: rtl/gpio_bank_dec.sv
`timescale 1ns/1ps
module gpio_bank_dec
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int UPPER_OFS = 'h800,
  parameter int PORTS     = 4,
  localparam int PORT_W   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              alias_o,
  output gpio_fn_e          fn_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int ALIAS_BIT = $clog2(UPPER_OFS);
  localparam int FN_LSB    = 2 + PORT_W;
  localparam int FN_MSB    = FN_LSB + 2;

  logic stray;

  always_comb begin
    stray = 1'b0;
    for (int i = FN_MSB + 1; i < ADDR_W; i++) begin
      if (i != ALIAS_BIT) stray = stray | addr_i[i];
    end
  end

  assign port_o  = addr_i[FN_LSB-1:2];
  assign fn_o    = gpio_fn_e'(addr_i[FN_MSB:FN_LSB]);
  assign alias_o = addr_i[ALIAS_BIT];
  assign hit_o   = !stray && (addr_i[1:0] == 2'b00) && (int'(port_o) < PORTS);
endmodule

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 8,
  localparam int LVL_W = 3 * PINS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             alias_i,
  input  gpio_fn_e         fn_i,
  input  logic [31:0]      wdata_i,
  output logic [PINS-1:0]  cnf_o,
  output logic [PINS-1:0]  oe_o,
  output logic [PINS-1:0]  out_o,
  output logic [PINS-1:0]  enb_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [PINS-1:0] mask, val;
  assign mask = wdata_i[2*PINS-1:PINS];
  assign val  = wdata_i[PINS-1:0];

  function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old,
                                            input logic [PINS-1:0] m,
                                            input logic [PINS-1:0] v);
    return (old & ~m) | (v & m);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnf_o <= '0;
      oe_o  <= '0;
      out_o <= '0;
      enb_o <= '0;
      lvl_o <= '0;
    end else if (sel_i) begin
      unique case (fn_i)
        FN_CNF: cnf_o <= alias_i ? merge(cnf_o, mask, val) : val;
        FN_OE:  oe_o  <= alias_i ? merge(oe_o, mask, val) : val;
        FN_OUT: out_o <= alias_i ? merge(out_o, mask, val) : val;
        FN_ENB: enb_o <= alias_i ? merge(enb_o, mask, val) : val;
        FN_LVL: begin
          if (alias_i) lvl_o[PINS-1:0] <= merge(lvl_o[PINS-1:0], mask, val);
          else         lvl_o <= wdata_i[LVL_W-1:0];
        end
        default: ;  // input, status and clear hold no writable state
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int UPPER_OFS = 'h800,
  parameter int PORTS     = 4,
  parameter int PINS      = 8,
  localparam int NPIN     = PORTS * PINS,
  localparam int PORT_W   = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int LVL_W    = 3 * PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  output logic [31:0]       rdata_o,
  input  logic [NPIN-1:0]   pad_i,
  output logic [NPIN-1:0]   pad_o,
  output logic [NPIN-1:0]   pad_oe_o
);
  logic              hit, is_alias;
  gpio_fn_e          fn;
  logic [PORT_W-1:0] port;
  logic [NPIN-1:0]   in_q;

  logic [PINS-1:0]  cnf_q [PORTS];
  logic [PINS-1:0]  oe_q  [PORTS];
  logic [PINS-1:0]  out_q [PORTS];
  logic [PINS-1:0]  enb_q [PORTS];
  logic [LVL_W-1:0] lvl_q [PORTS];

  gpio_bank_dec #(.ADDR_W(ADDR_W), .UPPER_OFS(UPPER_OFS), .PORTS(PORTS)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .alias_o(is_alias),
    .fn_o   (fn),
    .port_o (port)
  );

  gpio_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (in_q)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpio_port_regs #(.PINS(PINS)) u_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (we_i && hit && (int'(port) == p)),
      .alias_i(is_alias),
      .fn_i   (fn),
      .wdata_i(wdata_i),
      .cnf_o  (cnf_q[p]),
      .oe_o   (oe_q[p]),
      .out_o  (out_q[p]),
      .enb_o  (enb_q[p]),
      .lvl_o  (lvl_q[p])
    );
    assign pad_o[p*PINS +: PINS]    = out_q[p];
    assign pad_oe_o[p*PINS +: PINS] = cnf_q[p] & oe_q[p];
  end

  always_comb begin
    rdata_o = '0;
    if (hit && !is_alias) begin
      unique case (fn)
        FN_CNF:  rdata_o[PINS-1:0]  = cnf_q[port];
        FN_OE:   rdata_o[PINS-1:0]  = oe_q[port];
        FN_OUT:  rdata_o[PINS-1:0]  = out_q[port];
        FN_IN:   rdata_o[PINS-1:0]  = in_q[int'(port)*PINS +: PINS];
        FN_ENB:  rdata_o[PINS-1:0]  = enb_q[port];
        FN_LVL:  rdata_o[LVL_W-1:0] = lvl_q[port];
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk #(
  parameter int ADDR_W    = 12,
  parameter int UPPER_OFS = 'h800,
  parameter int PINS      = 8,
  parameter int NPIN      = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              we_i,
  input logic [31:0]       rdata_o,
  input logic [NPIN-1:0]   pad_o,
  input logic [NPIN-1:0]   pad_oe_o
);
  localparam int ALIAS_BIT = $clog2(UPPER_OFS);
  localparam logic [ADDR_W-1:0] A_OUT0   = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_OUT0_M = ADDR_W'('h20 + UPPER_OFS);

  logic [PINS-1:0] w_mask, w_val;
  assign w_mask = wdata_i[2*PINS-1:PINS];
  assign w_val  = wdata_i[PINS-1:0];

  a_r2_out_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_OUT0 |=> pad_o[PINS-1:0] == $past(w_val));

  a_r3_out_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_OUT0_M |=>
      pad_o[PINS-1:0] == (($past(pad_o[PINS-1:0]) & ~$past(w_mask)) | ($past(w_val) & $past(w_mask))));

  a_r3_empty_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i[ALIAS_BIT] && w_mask == '0 |=> $stable(pad_o) && $stable(pad_oe_o));

  a_r6_input_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (addr_i >> 4) == 3 && addr_i[1:0] == 2'b00 |=> $stable(pad_o) && $stable(pad_oe_o));

  a_r8_unaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[1:0] != 2'b00 |-> rdata_o == 32'd0);

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i < ADDR_W'('h40) |-> rdata_o[31:PINS] == '0);
endmodule

bind gpio_bank gpio_bank_chk #(
  .ADDR_W(ADDR_W), .UPPER_OFS(UPPER_OFS), .PINS(PINS), .NPIN(NPIN)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .rdata_o (rdata_o),
  .pad_o   (pad_o),
  .pad_oe_o(pad_oe_o)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(req, rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 cnf0", 12'h000, 0);
    rd_chk("R1 oe1", 12'h014, 0);
    rd_chk("R1 out2", 12'h028, 0);
    rd_chk("R1 enb3", 12'h05C, 0);
    rd_chk("R1 lvl0", 12'h060, 0);
    check("R1 pad_oe", pad_oe, 0);
  endtask

  task automatic t_plain;
    bus_wr(12'h024, 32'hFFFF_FF5A);
    rd_chk("R2 out1 readback", 12'h024, 32'h5A);
    check("R4 pad_o port1", {24'd0, pad_out[15:8]}, 32'h5A);
    bus_wr(12'h004, 32'h0000_00F0);
    bus_wr(12'h014, 32'h0000_003C);
    rd_chk("R2 oe1 readback", 12'h014, 32'h3C);
    check("R4 pad_oe port1", {24'd0, pad_oe[15:8]}, 32'h30);
    check("R9 other ports pad_o", {pad_out[31:16], 8'd0, pad_out[7:0]}, 0);
    check("R9 other ports pad_oe", {pad_oe[31:16], 8'd0, pad_oe[7:0]}, 0);
  endtask

  task automatic t_masked;
    bus_wr(12'h824, 32'h0000_0301);
    rd_chk("R3 out1 partial mask", 12'h024, 32'h59);
    bus_wr(12'h824, 32'h0000_00FF);
    rd_chk("R3 out1 empty mask", 12'h024, 32'h59);
    bus_wr(12'h804, 32'h0000_1000);
    rd_chk("R3 cnf1 clear bit4", 12'h004, 32'hE0);
    check("R4 pad_oe after cnf clear", {24'd0, pad_oe[15:8]}, 32'h20);
    bus_wr(12'h820, 32'h0000_FFA5);
    check("R3 out0 full mask", {24'd0, pad_out[7:0]}, 32'hA5);
    check("R9 out1 kept", {24'd0, pad_out[15:8]}, 32'h59);
  endtask

  task automatic t_input;
    @(negedge clk);
    pad_in = 32'hA5C3_0F11;
    addr = 12'h030;
    #1 check("R5 before sync", rdata, 0);
    @(negedge clk);
    #1 check("R5 after one edge", rdata, 0);
    @(negedge clk);
    #1 check("R5 after two edges", rdata, 32'h11);
    rd_chk("R5 port3", 12'h03C, 32'hA5);
  endtask

  task automatic t_ignore;
    bus_wr(12'h030, 32'hFFFF_FFFF);
    bus_wr(12'h830, 32'h0000_FFFF);
    bus_wr(12'h044, 32'hFFFF_FFFF);
    bus_wr(12'h074, 32'hFFFF_FFFF);
    rd_chk("R6 input unchanged", 12'h030, 32'h11);
    rd_chk("R6 status zero", 12'h044, 0);
    check("R6 pad_o kept", pad_out, 32'h0000_59A5);
    check("R6 pad_oe kept", pad_oe, 32'h0000_2000);
  endtask

  task automatic t_irq;
    bus_wr(12'h058, 32'hFFFF_FFAB);
    rd_chk("R7 enb2 plain", 12'h058, 32'hAB);
    bus_wr(12'h858, 32'h0000_0F00);
    rd_chk("R7 enb2 masked", 12'h058, 32'hA0);
    bus_wr(12'h068, 32'hFF12_3456);
    rd_chk("R7 lvl2 plain", 12'h068, 32'h0012_3456);
    bus_wr(12'h868, 32'h0000_FF00);
    rd_chk("R7 lvl2 masked low byte only", 12'h068, 32'h0012_3400);
  endtask

  task automatic t_undec;
    rd_chk("R8 unaligned", 12'h025, 0);
    rd_chk("R8 alias read", 12'h824, 0);
    rd_chk("R8 stray bit read", 12'h120, 0);
    bus_wr(12'h120, 32'h0000_00FF);
    bus_wr(12'h022, 32'h0000_00FF);
    rd_chk("R8 stray write ignored", 12'h020, 32'hA5);
    check("R8 pad_o kept", pad_out, 32'h0000_59A5);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_plain;
    t_masked;
    t_input;
    t_ignore;
    t_irq;
    t_undec;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule